// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller

This block gathers interrupt requests from peripheral lines and presents a single request to the processor. It contains two eight-line controller units. The primary unit drives the processor request. The secondary unit's request feeds line 2 of the primary, which gives sixteen lines in total. Overall lines 0, 1 and 3 to 7 belong to the primary. Overall lines 8 to 15 are lines 0 to 7 of the secondary. The external pin `irq_in[2]` is not used, because line 2 of the primary carries the secondary.

Each unit has the following state:
- a mask, one bit per line;
- a trigger mode per line, either rising-edge latched or level following;
- a five-bit vector base;
- an in-service set.

Within a unit, the lowest-numbered line has the highest priority. A line is offered only while no line of equal or higher priority is in service. The processor accepts a request by pulsing `int_ack` while its interrupt-enable input `cpu_ie` is high. The cycle after that, `vec_valid` is high for exactly one cycle and `vec` carries the vector of the chosen line. When primary line 2 wins, the vector is taken from the secondary unit, and both units mark their winning line as in service. Software finishes each service with an end-of-interrupt write to each unit involved.

The acknowledge forms a request/acknowledge pair. The processor signals readiness by acknowledging, so the vector output has no back-pressure: it is valid for one cycle only and must be captured in that cycle.

Top module: `irqc_cascade`

## Requirements
- R1: After reset, `int_req` and `vec_valid` are low. Every line of both units is masked and in edge mode, nothing is pending or in service, and both vector bases are zero.
- R2: In edge mode (mode bit 0), a rising edge on an unmasked line raises `int_req` after the next clock edge. The request stays latched after the line falls, until it is acknowledged.
- R3: In level mode (mode bit 1), the line's request follows the line one cycle late. A line that falls before it is acknowledged withdraws its request.
- R4: A line whose mask bit is 1 cannot raise `int_req`. An edge that arrives while the line is masked is still recorded, and it requests as soon as the mask bit is cleared.
- R5: When several eligible lines request at once, the lowest-numbered line is acknowledged.
- R6: An acknowledge is accepted at a clock edge where `int_ack`, `cpu_ie` and `int_req` are all high. In the following cycle `vec_valid` is high for one cycle and `vec` = {base[4:0], line[2:0]}. Without an accepted acknowledge, `vec_valid` stays low.
- R7: An accepted acknowledge clears the winner's pending request and sets its in-service bit. That line and all lower-priority lines of the unit are then held off. Higher-priority lines can still request, so services can nest.
- R8: An end-of-interrupt write (register code 3) clears only the highest-priority in-service bit of the addressed unit.
- R9: The secondary's request reaches primary line 2 with no added cycle, subject to primary mask bit 2. When line 2 wins, `vec` is the secondary's vector for its own winning line, and both units enter service.
- R10: While `cpu_ie` is low, `int_ack` is ignored. No vector is produced, and the pending state is unchanged.
- R11: A register write with `wr_en` high affects only the unit chosen by `wr_unit` (0 = primary, 1 = secondary). The register codes are:
  - 0: mask, `wr_data[7:0]`, bit n for line n;
  - 1: base, `wr_data[7:3]`;
  - 2: mode, `wr_data[7:0]`, 1 = level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Request lines; bits 15:8 go to the secondary, bit 2 is unused |
| cpu_ie | input | 1 | Processor interrupt-enable flag; low suppresses acknowledge |
| int_ack | input | 1 | Processor acknowledge pulse |
| int_req | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | One-cycle strobe marking `vec` |
| vec | output | 8 | Interrupt vector of the acknowledged line |
| wr_en | input | 1 | Register write strobe |
| wr_unit | input | 1 | Write target: 0 primary, 1 secondary |
| wr_sel | input | 2 | Register code: 0 mask, 1 base, 2 mode, 3 end-of-interrupt |
| wr_data | input | 8 | Write data |

## Verification
The assertions assume that request lines, `int_ack`, `cpu_ie` and the write port are synchronous to `clk`. They also assume that an acknowledge and an end-of-interrupt write to the same unit never fall in the same cycle. The bench drives every input on the falling clock edge and issues end-of-interrupt writes only in cycles without an acknowledge. It never drives `irq_in[2]`. Line activity comes as single-cycle pulses for edge lines and as held levels for level lines, so both trigger modes are exercised inside these assumptions.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  localparam int LINES_DEF = 8;
  localparam int VECW_DEF  = 8;

  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_BASE = 2'd1,
    SEL_MODE = 2'd2,
    SEL_EOI  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqc_line.sv
`timescale 1ns/1ps
// One request line: edge latch or level follower, or a plain pass-through
// for a line fed by a cascaded unit.
module irqc_line #(
  parameter bit PASS = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic level_mode,
  input  logic take,
  output logic pend
);
  generate
    if (PASS) begin : g_pass
      logic unused_pass;
      assign pend        = src;
      assign unused_pass = ^{clk, rst_n, level_mode, take};
    end else begin : g_latch
      logic prev_q;
      logic pend_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
          pend_q <= 1'b0;
        end else begin
          prev_q <= src;
          if (level_mode) pend_q <= src & ~take;
          else            pend_q <= (src & ~prev_q) | (pend_q & ~take);
        end
      end
      assign pend = pend_q;
    end
  endgenerate
endmodule

// File: rtl/irqc_resolve.sv
`timescale 1ns/1ps
// Fixed-priority pick: lowest index wins, and in-service lines block
// themselves and everything below them.
module irqc_resolve #(
  parameter int LINES = 8
) (
  input  logic [LINES-1:0]         cand,
  input  logic [LINES-1:0]         isr,
  output logic                     req,
  output logic [$clog2(LINES)-1:0] win,
  output logic [LINES-1:0]         top_isr
);
  localparam int IDXW = $clog2(LINES);
  logic blocked;
  logic found_isr;

  always_comb begin
    req     = 1'b0;
    win     = '0;
    blocked = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      blocked = blocked | isr[i];
      if (!req && cand[i] && !blocked) begin
        req = 1'b1;
        win = IDXW'(i);
      end
    end
  end

  always_comb begin
    top_isr   = '0;
    found_isr = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      if (!found_isr && isr[i]) begin
        found_isr  = 1'b1;
        top_isr[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqc_unit.sv
`timescale 1ns/1ps
// One eight-line controller unit with mask, mode, base and in-service state.
module irqc_unit
  import irqc_pkg::*;
#(
  parameter int               LINES     = LINES_DEF,
  parameter int               VECW      = VECW_DEF,
  parameter logic [LINES-1:0] PASS_MASK = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LINES-1:0]         src,
  input  logic                     take_en,
  input  logic                     wr_en,
  input  reg_sel_e                 wr_sel,
  input  logic [VECW-1:0]          wr_data,
  output logic                     req,
  output logic [$clog2(LINES)-1:0] win,
  output logic [VECW-1:0]          vec
);
  localparam int IDXW  = $clog2(LINES);
  localparam int BASEW = VECW - IDXW;

  logic [LINES-1:0] mask_q, mode_q, isr_q;
  logic [BASEW-1:0] base_q;
  logic [LINES-1:0] pend, take, cand, top_isr, eoi_clr;

  assign take = take_en ? (LINES'(1) << win) : '0;

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      irqc_line #(.PASS(PASS_MASK[g])) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .src        (src[g]),
        .level_mode (mode_q[g]),
        .take       (take[g]),
        .pend       (pend[g])
      );
    end
  endgenerate

  assign cand = pend & ~mask_q;

  irqc_resolve #(.LINES(LINES)) u_resolve (
    .cand    (cand),
    .isr     (isr_q),
    .req     (req),
    .win     (win),
    .top_isr (top_isr)
  );

  assign eoi_clr = (wr_en && wr_sel == SEL_EOI) ? top_isr : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      mode_q <= '0;
      base_q <= '0;
      isr_q  <= '0;
    end else begin
      isr_q <= (isr_q & ~eoi_clr) | take;
      if (wr_en) begin
        case (wr_sel)
          SEL_MASK: mask_q <= wr_data[LINES-1:0];
          SEL_BASE: base_q <= wr_data[VECW-1:IDXW];
          SEL_MODE: mode_q <= wr_data[LINES-1:0];
          default:  ;
        endcase
      end
    end
  end

  assign vec = {base_q, win};
endmodule

// File: rtl/irqc_cascade.sv
`timescale 1ns/1ps
// Primary and secondary units; the secondary feeds primary line CASC_LINE.
module irqc_cascade
  import irqc_pkg::*;
#(
  parameter int LINES     = LINES_DEF,
  parameter int VECW      = VECW_DEF,
  parameter int CASC_LINE = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*LINES-1:0] irq_in,
  input  logic               cpu_ie,
  input  logic               int_ack,
  output logic               int_req,
  output logic               vec_valid,
  output logic [VECW-1:0]    vec,
  input  logic               wr_en,
  input  logic               wr_unit,
  input  logic [1:0]         wr_sel,
  input  logic [VECW-1:0]    wr_data
);
  localparam int               IDXW     = $clog2(LINES);
  localparam logic [IDXW-1:0]  CASC_IDX = IDXW'(CASC_LINE);
  localparam logic [LINES-1:0] CASC_BIT = LINES'(1) << CASC_LINE;

  logic [LINES-1:0] pri_src;
  logic             pri_req, sec_req, accept, via_sec;
  logic [IDXW-1:0]  pri_win, sec_win;
  logic [VECW-1:0]  pri_vec, sec_vec;
  reg_sel_e         sel;
  logic             unused_casc_pin;
  logic             unused_sec_win;

  assign sel             = reg_sel_e'(wr_sel);
  assign unused_casc_pin = irq_in[CASC_LINE];
  assign unused_sec_win  = ^sec_win;

  always_comb begin
    pri_src            = irq_in[LINES-1:0];
    pri_src[CASC_LINE] = sec_req;
  end

  assign accept  = int_ack & cpu_ie & pri_req;
  assign via_sec = pri_win == CASC_IDX;

  irqc_unit #(.LINES(LINES), .VECW(VECW), .PASS_MASK(CASC_BIT)) u_pri (
    .clk     (clk),
    .rst_n   (rst_n),
    .src     (pri_src),
    .take_en (accept),
    .wr_en   (wr_en & ~wr_unit),
    .wr_sel  (sel),
    .wr_data (wr_data),
    .req     (pri_req),
    .win     (pri_win),
    .vec     (pri_vec)
  );

  irqc_unit #(.LINES(LINES), .VECW(VECW), .PASS_MASK('0)) u_sec (
    .clk     (clk),
    .rst_n   (rst_n),
    .src     (irq_in[2*LINES-1:LINES]),
    .take_en (accept & via_sec),
    .wr_en   (wr_en & wr_unit),
    .wr_sel  (sel),
    .wr_data (wr_data),
    .req     (sec_req),
    .win     (sec_win),
    .vec     (sec_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec       <= '0;
    end else begin
      vec_valid <= accept;
      if (accept) vec <= via_sec ? sec_vec : pri_vec;
    end
  end

  assign int_req = pri_req;
endmodule

// File: rtl/irqc_cascade_chk.sv
`timescale 1ns/1ps
module irqc_cascade_chk #(
  parameter int LINES     = 8,
  parameter int CASC_LINE = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     int_ack,
  input logic                     cpu_ie,
  input logic                     int_req,
  input logic                     vec_valid,
  input logic [$clog2(LINES)-1:0] pri_win,
  input logic                     sec_req
);
  localparam int              IDXW = $clog2(LINES);
  localparam logic [IDXW-1:0] CIDX = IDXW'(CASC_LINE);

  // R1: first cycle out of reset is quiet
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!int_req && !vec_valid));

  // R6: accepted acknowledge yields a vector strobe
  a_r6_vec_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && cpu_ie && int_req) |=> vec_valid);

  // R6: no strobe without an accepted acknowledge
  a_r6_vec_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(int_ack && cpu_ie && int_req));

  // R10: interrupt-enable low blocks any vector
  a_r10_ie_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ie |=> !vec_valid);

  // R9: cascade line only wins while the secondary requests
  a_r9_cascade_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && pri_win == CIDX) |-> sec_req);
endmodule

bind irqc_cascade irqc_cascade_chk #(.LINES(LINES), .CASC_LINE(CASC_LINE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .int_ack   (int_ack),
  .cpu_ie    (cpu_ie),
  .int_req   (int_req),
  .vec_valid (vec_valid),
  .pri_win   (pri_win),
  .sec_req   (sec_req)
);

// File: tb/irqc_cascade_test.sv
`timescale 1ns/1ps
module irqc_cascade_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic        cpu_ie = 1'b0;
  logic        int_ack = 1'b0;
  logic        int_req, vec_valid;
  logic [7:0]  vec;
  logic        wr_en = 1'b0;
  logic        wr_unit = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  irqc_cascade uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cpu_ie(cpu_ie),
    .int_ack(int_ack), .int_req(int_req), .vec_valid(vec_valid), .vec(vec),
    .wr_en(wr_en), .wr_unit(wr_unit), .wr_sel(wr_sel), .wr_data(wr_data)
  );

  // ---------------- behavioural reference ----------------
  int m_mask[2], m_base[2], m_mode[2];
  bit m_pend[2][8], m_isr[2][8], m_prev[2][8];
  bit m_vv;
  int m_vec;

  function automatic int mwin(int u);
    bit blk = 0;
    bit p;
    for (int i = 0; i < 8; i++) begin
      if (m_isr[u][i]) blk = 1;
      p = (u == 0 && i == 2) ? (mwin(1) >= 0) : m_pend[u][i];
      if (p && !((m_mask[u] >> i) & 1) && !blk) return i;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int u = 0; u < 2; u++) begin
        m_mask[u] = 255; m_base[u] = 0; m_mode[u] = 0;
        for (int i = 0; i < 8; i++) begin
          m_pend[u][i] = 0; m_isr[u][i] = 0; m_prev[u][i] = 0;
        end
      end
      m_vv = 0; m_vec = 0;
    end else begin
      int w0, w1, t0, t1;
      bit src, tk;
      w0 = mwin(0); w1 = mwin(1); t0 = -1; t1 = -1;
      if (int_ack && cpu_ie && w0 >= 0) begin
        m_vv = 1; t0 = w0;
        if (w0 == 2) begin m_vec = m_base[1] * 8 + w1; t1 = w1; end
        else m_vec = m_base[0] * 8 + w0;
      end else m_vv = 0;
      for (int u = 0; u < 2; u++)
        for (int i = 0; i < 8; i++) begin
          if (!(u == 0 && i == 2)) begin
            src = irq_in[u*8+i];
            tk = ((u == 0) ? t0 : t1) == i;
            if ((m_mode[u] >> i) & 1) m_pend[u][i] = src && !tk;
            else m_pend[u][i] = (src && !m_prev[u][i]) || (m_pend[u][i] && !tk);
            m_prev[u][i] = src;
          end
        end
      if (wr_en && wr_sel == 2'd3) begin
        for (int i = 0; i < 8; i++)
          if (m_isr[wr_unit][i]) begin m_isr[wr_unit][i] = 0; break; end
      end
      if (t0 >= 0) m_isr[0][t0] = 1;
      if (t1 >= 0) m_isr[1][t1] = 1;
      if (wr_en) begin
        case (wr_sel)
          2'd0: m_mask[wr_unit] = wr_data;
          2'd1: m_base[wr_unit] = wr_data >> 3;
          2'd2: m_mode[wr_unit] = wr_data;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string t, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(tag, "model int_req", int'(int_req), int'(mwin(0) >= 0));
      chk(tag, "model vec_valid", int'(vec_valid), int'(m_vv));
      if (m_vv) chk(tag, "model vec", int'(vec), m_vec);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(); @(negedge clk); endtask
  task automatic wr(int u, int s, int d);
    wr_en = 1; wr_unit = u[0]; wr_sel = s[1:0]; wr_data = d[7:0];
    tick();
    wr_en = 0;
  endtask
  task automatic ack(); int_ack = 1; tick(); int_ack = 0; endtask
  task automatic pulse(int l); irq_in[l] = 1; tick(); irq_in[l] = 0; endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    tag = "R1";
    chk("R1", "int_req after reset", int'(int_req), 0);
    chk("R1", "vec_valid after reset", int'(vec_valid), 0);

    tag = "R4";
    pulse(0); tick();
    chk("R4", "masked edge no request", int'(int_req), 0);
    wr(0, 0, 8'h00);
    chk("R4", "recorded edge after unmask", int'(int_req), 1);

    tag = "R6"; cpu_ie = 1;
    ack();
    chk("R6", "vec_valid", int'(vec_valid), 1);
    chk("R1", "zero base vector", int'(vec), 8'h00);
    tick();
    chk("R6", "vec_valid one cycle", int'(vec_valid), 0);
    chk("R7", "pending cleared", int'(int_req), 0);
    wr(0, 3, 0);

    tag = "R11";
    wr(0, 1, 8'h20); wr(1, 1, 8'h28);

    tag = "R5";
    irq_in[5] = 1; irq_in[3] = 1; tick(); irq_in[5] = 0; irq_in[3] = 0; tick();
    chk("R2", "edge latch survives fall", int'(int_req), 1);
    ack();
    chk("R5", "lowest line wins", int'(vec), 8'h23);
    chk("R7", "lower line held off", int'(int_req), 0);
    tag = "R7";
    pulse(1);
    chk("R7", "higher line nests", int'(int_req), 1);
    ack();
    chk("R7", "nested vector", int'(vec), 8'h21);
    tag = "R8";
    wr(0, 3, 0);
    chk("R8", "one EOI clears one level", int'(int_req), 0);
    wr(0, 3, 0);
    chk("R8", "second EOI releases line 5", int'(int_req), 1);
    ack();
    chk("R8", "line 5 vector", int'(vec), 8'h25);
    wr(0, 3, 0);

    tag = "R10";
    pulse(6); cpu_ie = 0;
    ack();
    chk("R10", "no vector with ie low", int'(vec_valid), 0);
    chk("R10", "request kept", int'(int_req), 1);
    cpu_ie = 1;
    ack();
    chk("R10", "vector after ie high", int'(vec), 8'h26);
    wr(0, 3, 0);

    tag = "R3";
    wr(0, 2, 8'h10);
    irq_in[4] = 1; tick();
    chk("R3", "level request", int'(int_req), 1);
    irq_in[4] = 0; tick();
    chk("R3", "level withdrawn", int'(int_req), 0);
    irq_in[4] = 1; tick();
    ack();
    chk("R3", "level vector", int'(vec), 8'h24);
    tick();
    chk("R7", "in-service blocks same line", int'(int_req), 0);
    irq_in[4] = 0;
    wr(0, 3, 0); tick();
    chk("R3", "level low after EOI", int'(int_req), 0);

    tag = "R9";
    wr(1, 0, 8'h00);
    pulse(13);
    chk("R9", "secondary request passes", int'(int_req), 1);
    ack();
    chk("R9", "secondary vector", int'(vec), 8'h2D);
    chk("R9", "both in service", int'(int_req), 0);
    wr(1, 3, 0); wr(0, 3, 0);
    wr(0, 0, 8'h04);
    pulse(8); tick();
    chk("R9", "cascade line masked", int'(int_req), 0);
    wr(0, 0, 8'h00);
    chk("R9", "cascade unmasked", int'(int_req), 1);
    ack();
    chk("R9", "secondary line 0 vector", int'(vec), 8'h28);
    wr(1, 3, 0); wr(0, 3, 0);

    tag = "R11";
    wr(1, 1, 8'h30);
    pulse(0); ack();
    chk("R11", "primary base untouched", int'(vec), 8'h20);
    wr(0, 3, 0);
    pulse(9); ack();
    chk("R11", "secondary base rewritten", int'(vec), 8'h31);
    wr(1, 3, 0); wr(0, 3, 0);
    repeat (4) tick();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule